// File: doc/BRIEF.md
# Pinned-Photodiode Line Timing Sequencer

This block produces the digital controls for one line of four-transistor pinned-photodiode pixels with a global shutter. A single reset control and a single transfer-gate control drive every pixel of the line at the same time. The block also produces two one-cycle strobes for the correlated-double-sampling path. The first strobe captures the reset reference level and the second captures the signal-plus-reset level.

A line start pulse launches the sequence. The sequence steps through the following phases:

1. A full reset, with both controls high.
2. Transfer-gate release, which starts exposure, followed by reset release after a fixed short delay.
3. The exposure window.
4. A timed reset pulse.
5. The reference strobe.
6. A timed transfer pulse.
7. The signal strobe.
8. A one-cycle line-done flag.

The exposure length, the reset pulse width and the transfer pulse width come from parallel configuration inputs. These inputs are captured when a line is accepted, so they may change freely during a line.

A line start that arrives while a sequence is running is dropped. It sets a sticky overrun flag, which software clears with a clear input.

Top module: `pd_line_seq`

## Requirements
- R1: One cycle after the clock edge that accepts `line_start` in idle, `pix_rst` and `pix_tg` both go high. They stay high together for Rw cycles, where Rw = max(`cfg_rst_on`, 1).
- R2: `pix_tg` falls first. `pix_rst` then stays high for REL_DLY further cycles (default 2) and falls with `pix_tg` still low.
- R3: The exposure window runs from the first cycle with `pix_tg` low to the start of the next reset pulse. It lasts W = max(`cfg_exposure`, REL_DLY+1) cycles, so a programmed exposure of zero gives REL_DLY+1 cycles.
- R4: The second reset pulse keeps `pix_rst` high with `pix_tg` low for Rw cycles.
- R5: After the reset pulse comes exactly one cycle with both controls low. Then `smp_n` is high for exactly one cycle.
- R6: After the `smp_n` cycle comes one cycle with everything low. Then `pix_tg` is high with `pix_rst` low for Tw cycles, where Tw = max(`cfg_tg_on`, 1).
- R7: After the transfer pulse comes one all-low cycle. Then `smp_s` is high for one cycle, then `line_done` is high for one cycle, then all outputs return low and the block is idle.
- R8: The three configuration inputs are used only as captured at the accepting edge. Changes during a line do not alter that line.
- R9: A `line_start` that arrives while a line runs, including the `line_done` cycle, leaves the outputs unchanged. It sets `overrun` from the next cycle. `overrun` stays set until `ovr_clear` is high at a clock edge, and setting wins over clearing.
- R10: While `rst_n` is low and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Request to begin a line |
| cfg_exposure | input | EXP_W | Exposure length in cycles |
| cfg_rst_on | input | PW_W | Reset pulse width in cycles |
| cfg_tg_on | input | PW_W | Transfer pulse width in cycles |
| ovr_clear | input | 1 | Clears the overrun flag |
| pix_rst | output | 1 | Pixel reset control |
| pix_tg | output | 1 | Pixel transfer-gate control |
| smp_n | output | 1 | Reset-level sample strobe |
| smp_s | output | 1 | Signal-level sample strobe |
| line_done | output | 1 | One-cycle end-of-line flag |
| overrun | output | 1 | Sticky dropped-start flag |

## Verification
Two situations are hard to reach from the ports.

The first is a start request that lands in the single `line_done` cycle. There the block looks almost idle, yet it must still drop the request. Directed lines place a second start exactly in that cycle, and also early in the full reset. The bench then confirms that the trace is unchanged, that the block returns to idle, and that the flag is set.

The second is the exposure clamp. The bench drives exposures of 0, of REL_DLY, of REL_DLY+1 and of REL_DLY+2. It also rewrites the configuration during a running line, while random lines cover the rest.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FULL, S_REL, S_EXPO, S_RPUL, S_GAP1,
    S_SMPN, S_GAP2, S_TPUL, S_GAP3, S_SMPS, S_DONE
  } seq_state_t;

  // Pulse width with zero promoted to one cycle.
  function automatic int unsigned pulse_len(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Cycles of exposure left once the reset release delay has run.
  // The total window is max(e, rel+1).
  function automatic int unsigned expo_tail(input int unsigned e,
                                            input int unsigned rel);
    return (e > rel) ? (e - rel) : 1;
  endfunction

endpackage

// File: rtl/pd_seq_cfg.sv
module pd_seq_cfg
  import pd_seq_pkg::*;
#(
  parameter int unsigned EXP_W   = 16,
  parameter int unsigned PW_W    = 8,
  parameter int unsigned REL_DLY = 2,
  parameter int unsigned CNT_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EXP_W-1:0] exposure,
  input  logic [PW_W-1:0]  rst_on,
  input  logic [PW_W-1:0]  tg_on,
  output logic [CNT_W-1:0] r_len,
  output logic [CNT_W-1:0] t_len,
  output logic [CNT_W-1:0] x_tail
);

  logic [CNT_W-1:0] r_new, t_new, x_new;
  logic [CNT_W-1:0] r_q, t_q, x_q;

  always_comb begin
    r_new = CNT_W'(pulse_len(32'(rst_on)));
    t_new = CNT_W'(pulse_len(32'(tg_on)));
    x_new = CNT_W'(expo_tail(32'(exposure), REL_DLY));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= CNT_W'(1);
      t_q <= CNT_W'(1);
      x_q <= CNT_W'(1);
    end else if (load) begin
      r_q <= r_new;
      t_q <= t_new;
      x_q <= x_new;
    end
  end

  // The accepting cycle sees the fresh values; later cycles see the held ones.
  assign r_len  = load ? r_new : r_q;
  assign t_len  = load ? t_new : t_q;
  assign x_tail = load ? x_new : x_q;

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int unsigned REL_DLY = 2,
  parameter int unsigned CNT_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] r_len,
  input  logic [CNT_W-1:0] t_len,
  input  logic [CNT_W-1:0] x_tail,
  output seq_state_t       state,
  output logic             busy,
  output logic             accept
);

  localparam logic [CNT_W-1:0] REL_LOAD = CNT_W'(REL_DLY - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  seq_state_t       nxt;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             seg_end;

  assign seg_end = (cnt == '0);
  assign busy    = (state != S_IDLE);
  assign accept  = start && !busy;

  always_comb begin
    nxt   = state;
    cnt_n = cnt;
    unique case (state)
      S_IDLE: if (start) begin nxt = S_FULL; cnt_n = r_len - ONE; end
      S_FULL: if (seg_end) begin nxt = S_REL; cnt_n = REL_LOAD; end
              else cnt_n = cnt - ONE;
      S_REL:  if (seg_end) begin nxt = S_EXPO; cnt_n = x_tail - ONE; end
              else cnt_n = cnt - ONE;
      S_EXPO: if (seg_end) begin nxt = S_RPUL; cnt_n = r_len - ONE; end
              else cnt_n = cnt - ONE;
      S_RPUL: if (seg_end) nxt = S_GAP1;
              else cnt_n = cnt - ONE;
      S_GAP1: nxt = S_SMPN;
      S_SMPN: nxt = S_GAP2;
      S_GAP2: begin nxt = S_TPUL; cnt_n = t_len - ONE; end
      S_TPUL: if (seg_end) nxt = S_GAP3;
              else cnt_n = cnt - ONE;
      S_GAP3: nxt = S_SMPS;
      S_SMPS: nxt = S_DONE;
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_n;
    end
  end

  AST_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && state != S_DONE) |=> state != S_IDLE) else $error("start not dropped"); // R9

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE) |=> state == S_IDLE) else $error("done not followed by idle"); // R7

endmodule

// File: rtl/pd_seq_decode.sv
module pd_seq_decode
  import pd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t state,
  output logic       pix_rst,
  output logic       pix_tg,
  output logic       smp_n,
  output logic       smp_s,
  output logic       line_done
);

  always_comb begin
    pix_rst   = (state == S_FULL) || (state == S_REL) || (state == S_RPUL);
    pix_tg    = (state == S_FULL) || (state == S_TPUL);
    smp_n     = (state == S_SMPN);
    smp_s     = (state == S_SMPS);
    line_done = (state == S_DONE);
  end

  AST_RST_FALLS_AFTER_TG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_rst) |-> !$past(pix_tg)) else $error("reset fell with transfer high"); // R2

  AST_N_GAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_n |-> (!pix_rst && !pix_tg && !$past(pix_rst))) else $error("N strobe not gapped"); // R5

  AST_S_GAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_s |-> (!pix_tg && !pix_rst && !$past(pix_tg))) else $error("S strobe not gapped"); // R7

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_n || smp_s) |=> (!smp_n && !smp_s)) else $error("strobe too long"); // R5

  AST_TG_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pix_tg) && !pix_rst) |-> !$past(smp_n)) else $error("transfer pulse lacks gap"); // R6

endmodule

// File: rtl/pd_line_seq.sv
module pd_line_seq
  import pd_seq_pkg::*;
#(
  parameter int unsigned EXP_W   = 16,
  parameter int unsigned PW_W    = 8,
  parameter int unsigned REL_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [EXP_W-1:0] cfg_exposure,
  input  logic [PW_W-1:0]  cfg_rst_on,
  input  logic [PW_W-1:0]  cfg_tg_on,
  input  logic             ovr_clear,
  output logic             pix_rst,
  output logic             pix_tg,
  output logic             smp_n,
  output logic             smp_s,
  output logic             line_done,
  output logic             overrun
);

  localparam int unsigned CNT_W = ((EXP_W > PW_W) ? EXP_W : PW_W) + 1;

  seq_state_t       state;
  logic             busy, accept;
  logic [CNT_W-1:0] r_len, t_len, x_tail;

  pd_seq_cfg #(
    .EXP_W(EXP_W), .PW_W(PW_W), .REL_DLY(REL_DLY), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .exposure(cfg_exposure), .rst_on(cfg_rst_on), .tg_on(cfg_tg_on),
    .r_len(r_len), .t_len(t_len), .x_tail(x_tail)
  );

  pd_seq_fsm #(
    .REL_DLY(REL_DLY), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(line_start),
    .r_len(r_len), .t_len(t_len), .x_tail(x_tail),
    .state(state), .busy(busy), .accept(accept)
  );

  pd_seq_decode u_dec (
    .clk(clk), .rst_n(rst_n), .state(state),
    .pix_rst(pix_rst), .pix_tg(pix_tg), .smp_n(smp_n),
    .smp_s(smp_s), .line_done(line_done)
  );

  logic ovr_set;
  assign ovr_set = line_start && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (ovr_set)   overrun <= 1'b1;
    else if (ovr_clear) overrun <= 1'b0;
  end

  AST_FULL_RESET_START: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !busy) |=> (pix_rst && pix_tg)) else $error("no full reset"); // R1

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && busy) |=> overrun) else $error("overrun not raised"); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clear) |=> overrun) else $error("overrun dropped"); // R9

endmodule

// File: tb/pd_line_seq_test.sv
`timescale 1ns/1ps
module pd_line_seq_test;

  localparam int EXP_W = 16;
  localparam int PW_W  = 8;
  localparam int REL   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic ovr_clear = 1'b0;
  logic [EXP_W-1:0] cfg_exposure = '0;
  logic [PW_W-1:0]  cfg_rst_on = '0;
  logic [PW_W-1:0]  cfg_tg_on = '0;
  logic pix_rst, pix_tg, smp_n, smp_s, line_done, overrun;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pd_line_seq #(.EXP_W(EXP_W), .PW_W(PW_W), .REL_DLY(REL)) uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .cfg_exposure(cfg_exposure), .cfg_rst_on(cfg_rst_on), .cfg_tg_on(cfg_tg_on),
    .ovr_clear(ovr_clear), .pix_rst(pix_rst), .pix_tg(pix_tg), .smp_n(smp_n),
    .smp_s(smp_s), .line_done(line_done), .overrun(overrun)
  );

  function automatic int wid(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int win(input int e);
    return (e > REL + 1) ? e : REL + 1;
  endfunction

  function automatic int line_len(input int e, input int r, input int t);
    return 2 * wid(r) + win(e) + wid(t) + 6;
  endfunction

  // Expected {rst, tg, smp_n, smp_s, done} at offset k after the accepting edge.
  function automatic logic [4:0] expv(input int k, input int e, input int r, input int t);
    int f, b;
    f = wid(r);
    b = f + win(e) + wid(r);
    if (k < f)                 return 5'b11000;
    if (k < f + REL)           return 5'b10000;
    if (k < f + win(e))        return 5'b00000;
    if (k < b)                 return 5'b10000;
    if (k == b + 1)            return 5'b00100;
    if (k >= b + 3 && k < b + 3 + wid(t)) return 5'b01000;
    if (k == b + 4 + wid(t))   return 5'b00010;
    if (k == b + 5 + wid(t))   return 5'b00001;
    return 5'b00000;
  endfunction

  function automatic string seg_req(input int k, input int e, input int r, input int t);
    int f, b;
    f = wid(r);
    b = f + win(e) + wid(r);
    if (k < f)               return "R1";
    if (k < f + REL)         return "R2";
    if (k < f + win(e))      return "R3";
    if (k < b)               return "R4";
    if (k < b + 2)           return "R5";
    if (k < b + 3 + wid(t))  return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  // Runs one line. extra_at >= 0 places a second start at that offset.
  task automatic run_line(input int e, input int r, input int t, input bit mid,
                          input int extra_at, input string what);
    int L;
    bit bad;
    logic [4:0] a, x;
    logic [4:0] a_bad, x_bad;
    string rq;
    L = line_len(e, r, t);
    bad = 1'b0;
    a_bad = '0; x_bad = '0; rq = "R1";
    @(negedge clk);
    cfg_exposure = EXP_W'(e);
    cfg_rst_on   = PW_W'(r);
    cfg_tg_on    = PW_W'(t);
    line_start   = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    if (mid) begin
      cfg_exposure = EXP_W'($urandom_range(0, 60));
      cfg_rst_on   = PW_W'($urandom_range(0, 9));
      cfg_tg_on    = PW_W'($urandom_range(0, 9));
    end
    for (int k = 0; k < L + 2; k++) begin
      a = {pix_rst, pix_tg, smp_n, smp_s, line_done};
      x = expv(k, e, r, t);
      if (a !== x && !bad) begin
        bad = 1'b1; a_bad = a; x_bad = x;
        rq = (k >= L) ? "R7" : seg_req(k, e, r, t);
      end
      line_start = (k == extra_at);
      @(negedge clk);
    end
    line_start = 1'b0;
    check(!bad, mid ? "R8" : rq, int'(a_bad), int'(x_bad), what);
    if (mid && bad) $display("  first mismatch segment %s", rq);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R10: outputs during and after reset
    #9;
    check({pix_rst, pix_tg, smp_n, smp_s, line_done, overrun} == 6'b0, "R10", 
          int'({pix_rst, pix_tg, smp_n, smp_s, line_done, overrun}), 0, "in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check({pix_rst, pix_tg, smp_n, smp_s, line_done, overrun} == 6'b0, "R10",
          int'({pix_rst, pix_tg, smp_n, smp_s, line_done, overrun}), 0, "after reset");

    // Directed corner cases
    run_line(0, 0, 0, 1'b0, -1, "R3 zero exposure, unit pulses");
    run_line(REL, 1, 1, 1'b0, -1, "R3 exposure at release delay");
    run_line(REL + 1, 3, 2, 1'b0, -1, "R3 exposure at clamp edge");
    run_line(REL + 2, 2, 4, 1'b0, -1, "R3 exposure just above clamp");
    run_line(300, 7, 5, 1'b0, -1, "R4 long exposure");
    run_line(10, 4, 3, 1'b1, -1, "R8 config rewritten mid-line");
    check(overrun == 1'b0, "R9", int'(overrun), 0, "no overrun yet");

    // R9: start in the full reset
    run_line(8, 3, 2, 1'b0, 1, "R9 start during full reset");
    check(overrun == 1'b1, "R9", int'(overrun), 1, "overrun set after full-reset start");
    repeat (5) @(negedge clk);
    check(overrun == 1'b1, "R9", int'(overrun), 1, "overrun sticky");
    ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0;
    check(overrun == 1'b0, "R9", int'(overrun), 0, "overrun cleared");

    // R9: start in the line-done cycle
    run_line(5, 2, 2, 1'b0, line_len(5, 2, 2) - 1, "R9 start during line-done");
    check(overrun == 1'b1, "R9", int'(overrun), 1, "overrun set after done-cycle start");
    ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0;
    check(overrun == 1'b0, "R9", int'(overrun), 0, "overrun cleared again");

    // Random lines
    for (int i = 0; i < 40; i++) begin
      run_line(int'($urandom_range(0, 50)), int'($urandom_range(0, 8)),
               int'($urandom_range(0, 8)), ($urandom_range(0, 3) == 0), -1, "random line");
    end
    check(overrun == 1'b0, "R9", int'(overrun), 0, "no overrun after clean lines");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule